// File: doc/BRIEF.md
# Double-Buffered Audio Sample Address Sequencer

This block produces the memory word addresses that a serial audio port needs to stream samples continuously in both directions. Software sets a receive pointer, a transmit pointer and one block length, counted in 32-bit words, that both directions share. When a transfer starts, and again each time a block of that length completes, each enabled direction copies its pointer into a private shadow register and raises a pointer-updated event. Software can then program the next buffer while the current one is being filled or drained, and swap between two buffers without gaps.

For each word the serializer signals a per-direction done strobe. The active address then steps forward by four bytes from the shadowed pointer. A stop strobe ends the transfer and raises a stopped event. The three event flags are sticky. Each one has an interrupt enable, and a single interrupt line reports any enabled flag that is set.

Top module: `sbuf_seq`

## Requirements
- R1: After reset both request outputs, all event pulses, all event flags, all interrupt enables and `irq_o` are 0.
- R2: The cycle after an accepted start, each enabled direction asserts its request with the address equal to its pointer with bits 1:0 cleared. Its pointer-updated pulse (bit 0 receive, bit 1 transmit) is high for that cycle, and the matching flag is set.
- R3: Each done strobe of an active direction moves its address up by 4 in the following cycle, as long as the block is not complete.
- R4: The done strobe that completes a block of N words restarts the address at the pointer value present at that strobe and pulses that direction's pointer-updated event again.
- R5: A pointer written while a block runs has no effect on the addresses of that block.
- R6: The length is captured at each block start. A later change of `blk_len_i` affects only the next block, and a length of 0 acts as 1.
- R7: While a direction's enable is low its request is low, its done strobes are ignored and no start produces its pointer-updated event. When it is re-enabled during a transfer, it loads its pointer in the next cycle and raises its pointer-updated event.
- R8: A stop drops both requests in the next cycle and pulses and sets the stopped event (bit 2). Stop wins over a start in the same cycle, and a start during a transfer is ignored.
- R9: An event flag stays set until a 1 is written to its bit of `evt_clr_i`. A new event in the same cycle as a clear leaves the flag set.
- R10: `ien_we_i` loads `ien_o` from `ien_wdata_i`. Otherwise bits in `ien_set_i` are set and bits in `ien_clr_i` are cleared, and set wins when both name the same bit.
- R11: `irq_o` is 1 exactly when some event flag and its enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe |
| stop_i | input | 1 | Stop strobe |
| rx_en_i | input | 1 | Receive direction enable |
| tx_en_i | input | 1 | Transmit direction enable |
| rx_done_i | input | 1 | Receive word completed by the serializer |
| tx_done_i | input | 1 | Transmit word consumed by the serializer |
| rx_ptr_i | input | PTR_W | Next receive buffer byte address |
| tx_ptr_i | input | PTR_W | Next transmit buffer byte address |
| blk_len_i | input | LEN_W | Block length in 32-bit words |
| evt_clr_i | input | 3 | Write-one-to-clear of the event flags |
| ien_we_i | input | 1 | Direct write strobe for the interrupt enables |
| ien_wdata_i | input | 3 | Interrupt enable value for a direct write |
| ien_set_i | input | 3 | Write-one-to-set of the interrupt enables |
| ien_clr_i | input | 3 | Write-one-to-clear of the interrupt enables |
| rx_req_o | output | 1 | Receive memory write request |
| rx_addr_o | output | PTR_W | Receive memory byte address |
| tx_req_o | output | 1 | Transmit memory read request |
| tx_addr_o | output | PTR_W | Transmit memory byte address |
| evt_pulse_o | output | 3 | One-cycle event pulses (0 rx update, 1 tx update, 2 stopped) |
| evt_flag_o | output | 3 | Sticky event flags, same bit order |
| ien_o | output | 3 | Interrupt enables, same bit order |
| irq_o | output | 1 | Interrupt request |

## Verification
Every strobe is taken at one clock edge, and its result is visible from that edge onward. This applies to start, stop and done in the address and request outputs, to the event pulses and flags, and to `ien_o`. `irq_o` follows the flag and enable registers in the same cycle. A request falls in the same cycle its enable falls. The bench drives inputs on the falling edge, advances one rising edge and samples on the next falling edge. Each expected address is therefore compared one edge after the done strobe that produced it. The block-boundary base is the pointer value held at that strobe.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
    localparam int NUM_EVT   = 3;
    localparam int EVT_RXUPD = 0;
    localparam int EVT_TXUPD = 1;
    localparam int EVT_STOP  = 2;
    localparam int NUM_DIR   = 2;
    localparam int DIR_RX    = 0;
    localparam int DIR_TX    = 1;
endpackage

// File: rtl/sbuf_chan.sv
module sbuf_chan #(
    parameter int PTR_W = 31,
    parameter int LEN_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             run_i,
    input  logic             stop_i,
    input  logic             en_i,
    input  logic             done_i,
    input  logic [PTR_W-1:0] ptr_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             req_o,
    output logic [PTR_W-1:0] addr_o,
    output logic             upd_o
);
    localparam int WP_W = PTR_W - 2;

    typedef struct packed {
        logic             loaded;
        logic [WP_W-1:0]  base;
        logic [LEN_W-1:0] idx;
        logic [LEN_W-1:0] last;
    } chan_t;

    chan_t st_q, st_d;
    logic  active;
    logic  at_end;
    logic  load;

    always_comb begin
        st_d   = st_q;
        active = (start_i | run_i) & en_i & ~stop_i;
        at_end = (st_q.idx == st_q.last);
        load   = active & (~st_q.loaded | (done_i & at_end));
        if (!active) begin
            st_d.loaded = 1'b0;
            st_d.idx    = '0;
        end else if (load) begin
            st_d.loaded = 1'b1;
            st_d.base   = ptr_i[PTR_W-1:2];
            st_d.idx    = '0;
            st_d.last   = (len_i == '0) ? '0 : len_i - 1'b1;
        end else if (done_i) begin
            st_d.idx    = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o  = st_q.loaded & en_i;
    assign addr_o = {st_q.base + {{(WP_W-LEN_W){1'b0}}, st_q.idx}, 2'b00};
    assign upd_o  = load;
endmodule

// File: rtl/sbuf_evt.sv
module sbuf_evt #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         ien_we_i,
    input  logic [N-1:0] ien_wdata_i,
    input  logic [N-1:0] ien_set_i,
    input  logic [N-1:0] ien_clr_i,
    output logic [N-1:0] pulse_o,
    output logic [N-1:0] flag_o,
    output logic [N-1:0] ien_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [N-1:0] pulse;
        logic [N-1:0] flag;
        logic [N-1:0] ien;
    } evt_t;

    evt_t ev_q, ev_d;

    always_comb begin
        ev_d       = ev_q;
        ev_d.pulse = set_i;
        ev_d.flag  = (ev_q.flag & ~clr_i) | set_i;
        if (ien_we_i) begin
            ev_d.ien = ien_wdata_i;
        end else begin
            ev_d.ien = (ev_q.ien & ~ien_clr_i) | ien_set_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q <= '0;
        end else begin
            ev_q <= ev_d;
        end
    end

    assign pulse_o = ev_q.pulse;
    assign flag_o  = ev_q.flag;
    assign ien_o   = ev_q.ien;
    assign irq_o   = |(ev_q.flag & ev_q.ien);
endmodule

// File: rtl/sbuf_seq.sv
module sbuf_seq
    import sbuf_pkg::*;
#(
    parameter int PTR_W = 31,
    parameter int LEN_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic               rx_en_i,
    input  logic               tx_en_i,
    input  logic               rx_done_i,
    input  logic               tx_done_i,
    input  logic [PTR_W-1:0]   rx_ptr_i,
    input  logic [PTR_W-1:0]   tx_ptr_i,
    input  logic [LEN_W-1:0]   blk_len_i,
    input  logic [NUM_EVT-1:0] evt_clr_i,
    input  logic               ien_we_i,
    input  logic [NUM_EVT-1:0] ien_wdata_i,
    input  logic [NUM_EVT-1:0] ien_set_i,
    input  logic [NUM_EVT-1:0] ien_clr_i,
    output logic               rx_req_o,
    output logic [PTR_W-1:0]   rx_addr_o,
    output logic               tx_req_o,
    output logic [PTR_W-1:0]   tx_addr_o,
    output logic [NUM_EVT-1:0] evt_pulse_o,
    output logic [NUM_EVT-1:0] evt_flag_o,
    output logic [NUM_EVT-1:0] ien_o,
    output logic               irq_o
);
    typedef struct packed {
        logic run;
    } ctl_t;

    ctl_t ctl_q, ctl_d;
    logic start_acc;

    logic [NUM_DIR-1:0]            en_v;
    logic [NUM_DIR-1:0]            done_v;
    logic [NUM_DIR-1:0][PTR_W-1:0] ptr_v;
    logic [NUM_DIR-1:0]            req_v;
    logic [NUM_DIR-1:0][PTR_W-1:0] addr_v;
    logic [NUM_DIR-1:0]            upd_v;
    logic [NUM_EVT-1:0]            evt_set;

    always_comb begin
        ctl_d     = ctl_q;
        start_acc = start_i & ~ctl_q.run & ~stop_i;
        if (stop_i) begin
            ctl_d.run = 1'b0;
        end else if (start_acc) begin
            ctl_d.run = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign en_v[DIR_RX]   = rx_en_i;
    assign en_v[DIR_TX]   = tx_en_i;
    assign done_v[DIR_RX] = rx_done_i;
    assign done_v[DIR_TX] = tx_done_i;
    assign ptr_v[DIR_RX]  = rx_ptr_i;
    assign ptr_v[DIR_TX]  = tx_ptr_i;

    for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
        sbuf_chan #(
            .PTR_W (PTR_W),
            .LEN_W (LEN_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (start_acc),
            .run_i   (ctl_q.run),
            .stop_i  (stop_i),
            .en_i    (en_v[g]),
            .done_i  (done_v[g]),
            .ptr_i   (ptr_v[g]),
            .len_i   (blk_len_i),
            .req_o   (req_v[g]),
            .addr_o  (addr_v[g]),
            .upd_o   (upd_v[g])
        );
    end

    assign evt_set[EVT_RXUPD] = upd_v[DIR_RX];
    assign evt_set[EVT_TXUPD] = upd_v[DIR_TX];
    assign evt_set[EVT_STOP]  = stop_i;

    sbuf_evt #(
        .N (NUM_EVT)
    ) u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (evt_set),
        .clr_i       (evt_clr_i),
        .ien_we_i    (ien_we_i),
        .ien_wdata_i (ien_wdata_i),
        .ien_set_i   (ien_set_i),
        .ien_clr_i   (ien_clr_i),
        .pulse_o     (evt_pulse_o),
        .flag_o      (evt_flag_o),
        .ien_o       (ien_o),
        .irq_o       (irq_o)
    );

    assign rx_req_o  = req_v[DIR_RX];
    assign rx_addr_o = addr_v[DIR_RX];
    assign tx_req_o  = req_v[DIR_TX];
    assign tx_addr_o = addr_v[DIR_TX];
endmodule

// File: rtl/sbuf_seq_chk.sv
module sbuf_seq_chk #(
    parameter int PTR_W = 31
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stop_i,
    input logic             rx_en_i,
    input logic             tx_en_i,
    input logic             rx_done_i,
    input logic [2:0]       evt_clr_i,
    input logic             ien_we_i,
    input logic [2:0]       ien_set_i,
    input logic             rx_req_o,
    input logic [PTR_W-1:0] rx_addr_o,
    input logic             tx_req_o,
    input logic [2:0]       evt_pulse_o,
    input logic [2:0]       evt_flag_o,
    input logic [2:0]       ien_o
);
    // R8
    stop_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!rx_req_o && !tx_req_o));
    // R8
    stop_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (evt_pulse_o[2] && evt_flag_o[2]));
    // R2
    rx_load_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_req_o) |-> evt_pulse_o[0]);
    // R2
    tx_load_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_req_o) |-> evt_pulse_o[1]);
    // R3
    rx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_req_o && $past(rx_req_o && rx_done_i && rx_en_i) && !evt_pulse_o[0])
        |-> (rx_addr_o == $past(rx_addr_o) + PTR_W'(4)));
    // R7
    rx_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en_i |-> !rx_req_o);
    // R7
    tx_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en_i |-> !tx_req_o);
    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_flag_o[0] && !evt_clr_i[0]) |=> evt_flag_o[0]);
    // R10
    ien_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ien_we_i && ien_set_i != 3'b000) |=> ((ien_o & $past(ien_set_i)) == $past(ien_set_i)));
endmodule

bind sbuf_seq sbuf_seq_chk #(.PTR_W(PTR_W)) u_sbuf_seq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_i      (stop_i),
    .rx_en_i     (rx_en_i),
    .tx_en_i     (tx_en_i),
    .rx_done_i   (rx_done_i),
    .evt_clr_i   (evt_clr_i),
    .ien_we_i    (ien_we_i),
    .ien_set_i   (ien_set_i),
    .rx_req_o    (rx_req_o),
    .rx_addr_o   (rx_addr_o),
    .tx_req_o    (tx_req_o),
    .evt_pulse_o (evt_pulse_o),
    .evt_flag_o  (evt_flag_o),
    .ien_o       (ien_o)
);

// File: tb/sbuf_seq_bench.sv
module sbuf_seq_bench;
    localparam int PTR_W = 31;
    localparam int LEN_W = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, stop_i = 0, rx_en_i = 0, tx_en_i = 0;
    logic rx_done_i = 0, tx_done_i = 0;
    logic [PTR_W-1:0] rx_ptr_i = '0, tx_ptr_i = '0;
    logic [LEN_W-1:0] blk_len_i = '0;
    logic [2:0] evt_clr_i = '0, ien_wdata_i = '0, ien_set_i = '0, ien_clr_i = '0;
    logic ien_we_i = 0;
    logic rx_req_o, tx_req_o, irq_o;
    logic [PTR_W-1:0] rx_addr_o, tx_addr_o;
    logic [2:0] evt_pulse_o, evt_flag_o, ien_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    sbuf_seq #(.PTR_W(PTR_W), .LEN_W(LEN_W)) u_sbuf_seq (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [PTR_W-1:0] al(input logic [PTR_W-1:0] p);
        return p & ~PTR_W'(3);
    endfunction

    initial begin
        logic [PTR_W-1:0] rb, tb, a0;
        @(negedge clk);
        step();
        // R1 reset state
        chk("R1 rx_req", rx_req_o, 0);
        chk("R1 tx_req", tx_req_o, 0);
        chk("R1 pulses", evt_pulse_o, 0);
        chk("R1 flags", evt_flag_o, 0);
        chk("R1 ien", ien_o, 0);
        chk("R1 irq", irq_o, 0);
        rst_n = 1'b1;
        step();

        // R2 R3 R4 R5 R6 sweep over block lengths 0..5
        rx_en_i = 1; tx_en_i = 1;
        for (int l = 0; l < 6; l++) begin
            automatic int eff = (l == 0) ? 1 : l;
            blk_len_i = LEN_W'(l);
            rx_ptr_i = PTR_W'(32'h100 + l * 32'h40 + 3);
            tx_ptr_i = PTR_W'(32'h8000 + l * 32'h80 + 1);
            rb = al(rx_ptr_i); tb = al(tx_ptr_i);
            start_i = 1; step(); start_i = 0;
            chk("R2 rx_req", rx_req_o, 1);
            chk("R2 tx_req", tx_req_o, 1);
            for (int blk = 0; blk < 2; blk++) begin
                for (int w = 0; w < eff; w++) begin
                    chk("R3 rx_addr", rx_addr_o, rb + PTR_W'(4 * w));
                    chk("R3 tx_addr", tx_addr_o, tb + PTR_W'(4 * w));
                    chk("R4 upd pulses", evt_pulse_o[1:0], (w == 0) ? 2'b11 : 2'b00);
                    if (blk == 0 && w == 0) begin
                        // R5 pointer change takes effect next block
                        rx_ptr_i = rx_ptr_i + PTR_W'(32'h1000);
                        tx_ptr_i = tx_ptr_i + PTR_W'(32'h2000);
                    end
                    rx_done_i = 1; tx_done_i = 1; step();
                    rx_done_i = 0; tx_done_i = 0;
                end
                rb = al(rx_ptr_i); tb = al(tx_ptr_i);
            end
            chk("R4 rx new base", rx_addr_o, rb);
            chk("R4 tx new base", tx_addr_o, tb);
            chk("R4 upd pulse", evt_pulse_o[1:0], 2'b11);
            stop_i = 1; step(); stop_i = 0;
            chk("R8 rx_req off", rx_req_o, 0);
            chk("R8 tx_req off", tx_req_o, 0);
            chk("R8 stopped pulse", evt_pulse_o, 3'b100);
            evt_clr_i = 3'b111; step(); evt_clr_i = 0;
        end

        // R6 length captured at block start
        blk_len_i = 3; rx_ptr_i = 31'h400; tx_en_i = 0;
        start_i = 1; step(); start_i = 0;
        blk_len_i = 1;
        for (int w = 0; w < 3; w++) begin
            chk("R6 latched len addr", rx_addr_o, 31'h400 + PTR_W'(4 * w));
            rx_done_i = 1; step(); rx_done_i = 0;
        end
        chk("R6 boundary pulse", evt_pulse_o[0], 1);
        rx_done_i = 1; step(); rx_done_i = 0;
        chk("R6 one-word block", evt_pulse_o[0], 1);
        chk("R6 one-word addr", rx_addr_o, 31'h400);

        // R7 disabled transmit
        chk("R7 tx_req low", tx_req_o, 0);
        chk("R7 no tx pulse", evt_pulse_o[1], 0);
        tx_ptr_i = 31'h2004;
        tx_done_i = 1; step(); tx_done_i = 0;
        chk("R7 tx still idle", tx_req_o, 0);
        tx_en_i = 1; step();
        chk("R7 tx reload req", tx_req_o, 1);
        chk("R7 tx reload addr", tx_addr_o, 31'h2004);
        chk("R7 tx reload pulse", evt_pulse_o[1], 1);
        rx_en_i = 0; step();
        chk("R7 rx dropped", rx_req_o, 0);
        rx_en_i = 1; step();

        // R8 start during a transfer ignored
        rx_done_i = 1; step(); rx_done_i = 0;
        a0 = rx_addr_o;
        rx_ptr_i = 31'h7000;
        start_i = 1; step(); start_i = 0;
        chk("R8 start ignored addr", rx_addr_o, a0);
        chk("R8 start ignored pulse", evt_pulse_o[0], 0);
        stop_i = 1; step(); stop_i = 0;
        evt_clr_i = 3'b111; step(); evt_clr_i = 0;
        start_i = 1; stop_i = 1; step(); start_i = 0; stop_i = 0;
        chk("R8 stop wins req", rx_req_o, 0);
        chk("R8 stop wins pulse", evt_pulse_o, 3'b100);

        // R9 sticky flags, set beats clear
        step();
        chk("R9 flag sticky", evt_flag_o, 3'b100);
        evt_clr_i = 3'b100; step(); evt_clr_i = 0;
        chk("R9 cleared", evt_flag_o, 3'b000);
        evt_clr_i = 3'b001; start_i = 1; step(); evt_clr_i = 0; start_i = 0;
        chk("R9 set beats clear", evt_flag_o[0], 1);
        stop_i = 1; step(); stop_i = 0;
        evt_clr_i = 3'b111; step(); evt_clr_i = 0;
        chk("R9 all clear", evt_flag_o, 0);

        // R10 interrupt enables
        ien_we_i = 1; ien_wdata_i = 3'b101; step(); ien_we_i = 0;
        chk("R10 direct write", ien_o, 3'b101);
        ien_set_i = 3'b010; ien_clr_i = 3'b001; step();
        chk("R10 set and clear", ien_o, 3'b110);
        ien_set_i = 3'b100; ien_clr_i = 3'b100; step();
        chk("R10 set wins", ien_o, 3'b110);
        ien_we_i = 1; ien_wdata_i = 3'b001; ien_set_i = 3'b110; ien_clr_i = 0; step();
        ien_we_i = 0; ien_set_i = 0;
        chk("R10 write priority", ien_o, 3'b001);

        // R11 interrupt line
        chk("R11 irq idle", irq_o, 0);
        stop_i = 1; step(); stop_i = 0;
        chk("R11 flag not enabled", irq_o, 0);
        ien_set_i = 3'b100; step(); ien_set_i = 0;
        chk("R11 irq asserted", irq_o, 1);
        evt_clr_i = 3'b100; step(); evt_clr_i = 0;
        chk("R11 irq released", irq_o, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule